// File: doc/BRIEF.md
# Phase-Shifted Bridge Gate Generator

This block produces the six gate-drive enables of a phase-shifted full-bridge DC/DC converter: two complementary pairs for the primary bridge legs and two synchronous-rectifier drives for the secondary side. The leading leg divides a fixed-rate reference pulse train by two. The lagging leg divides the pulse train from the peak-current PWM comparator by two. The phase shift between the legs therefore follows the comparator, and this shift sets the power delivered.

Each leg output has a programmable rising-edge delay that acts as dead time, so the two switches of one leg never conduct together. Falling edges are not delayed. Two set/clear latches merge the primary outputs into the rectifier drives. All timing is counted in system-clock cycles. A global enable shuts every output off within one cycle. After the enable returns, switching restarts cleanly on the next input edge.

Top module: `psfb_gate_gen`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, all six outputs are low on the following cycle, and both leg states, both arm flags and both rectifier latches are cleared.
- R2: `ref_pulse_i` passes through a two-stage synchronizer. The leading-leg state flips on the third rising clock edge that samples the input high after it was low. The first flip after enable or reset makes the state true, which drives the `gate_a` side; `gate_b` is driven from the complement.
- R3: `pwm_pulse_i` drives the lagging leg (`gate_c` true side, `gate_d` complement) with the same synchronizer latency and toggle rule as R2.
- R4: Each gate output rises exactly `dead_cycles` clock cycles after its side of the leg state becomes high. It falls in the same cycle that side goes low. With `dead_cycles` = 0 there is no delay. For an input train of period P cycles, each gate therefore stays high for P − `dead_cycles` cycles.
- R5: The two outputs of one leg are never high in the same cycle.
- R6: `rect_e` is set by `gate_a` and cleared by `gate_c`. `rect_f` is set by `gate_b` and cleared by `gate_d`. Both latches are registered, take one cycle, and clear wins when set and clear are high together.
- R7: When `en` is sampled low, all six outputs are low from the next cycle on. A leg resumes only on its first input edge with `en` high, and its outputs then wait the full dead time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global output enable |
| dead_cycles | input | DEAD_W | Rising-edge delay in clock cycles |
| ref_pulse_i | input | 1 | Asynchronous fixed-rate reference pulse train (leading leg) |
| pwm_pulse_i | input | 1 | Asynchronous comparator PWM pulse train (lagging leg) |
| gate_a | output | 1 | Leading leg, true side |
| gate_b | output | 1 | Leading leg, complement side |
| gate_c | output | 1 | Lagging leg, true side |
| gate_d | output | 1 | Lagging leg, complement side |
| rect_e | output | 1 | Rectifier drive set by A, cleared by C |
| rect_f | output | 1 | Rectifier drive set by B, cleared by D |

## Verification
The hardest condition to reach is a rectifier latch that sees its set and clear inputs rise in the same cycle. Only then does the clear-wins priority show at the ports. To reach it, the bench resets the block, re-enables it, and drives both pulse inputs with identical waveforms. This makes the two leg states flip in the same cycle, so that `gate_a` equals `gate_c` and `gate_b` equals `gate_d`, and both rectifier drives must then stay low throughout. The other cases are covered by a reference model scoreboard that runs through several phase offsets, dead times and enable drops, and by measuring gate high times.

// File: rtl/psfb_pkg.sv
package psfb_pkg;

    localparam int LEG_COUNT  = 2;
    localparam int SIDE_COUNT = 2;
    localparam int LEG_LEAD   = 0;
    localparam int LEG_LAG    = 1;

    typedef struct packed {
        logic comp_o;
        logic true_o;
    } gate_pair_t;

    // level presented to a side's delay cell: nothing until the leg is armed
    function automatic logic side_level(input logic armed, input logic state, input logic comp_side);
        return armed & (comp_side ? ~state : state);
    endfunction

endpackage

// File: rtl/psfb_edge_sync.sv
module psfb_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-1:0], async_i};
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o); // R2

endmodule

// File: rtl/psfb_rise_delay.sv
module psfb_rise_delay #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          level_i,
    input  logic [CW-1:0] dead_i,
    output logic          gate_o
);
    localparam logic [CW-1:0] HELD_MAX = '1;

    logic [CW-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst || !level_i)        held_q <= '0;
        else if (held_q != HELD_MAX) held_q <= held_q + 1'b1;
    end

    assign gate_o = level_i && (held_q >= dead_i);

    AST_RISE_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((dead_i != '0) && $rose(gate_o)) |-> $past(level_i)); // R4

endmodule

// File: rtl/psfb_leg.sv
module psfb_leg
    import psfb_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          flip_i,
    input  logic [CW-1:0] dead_i,
    output gate_pair_t    gate_o
);
    logic state_q;
    logic armed_q;
    logic [SIDE_COUNT-1:0] lvl;
    logic [SIDE_COUNT-1:0] gate;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q <= 1'b0;
            armed_q <= 1'b0;
        end else if (flip_i) begin
            state_q <= ~state_q;
            armed_q <= 1'b1;
        end
    end

    for (genvar s = 0; s < SIDE_COUNT; s++) begin : g_side
        assign lvl[s] = side_level(armed_q, state_q, s[0]);
        psfb_rise_delay #(.CW(CW)) delay_i (
            .clk     (clk),
            .rst     (rst),
            .level_i (lvl[s]),
            .dead_i  (dead_i),
            .gate_o  (gate[s])
        );
    end

    assign gate_o.true_o = gate[0];
    assign gate_o.comp_o = gate[1];

    AST_PAIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(gate[0] && gate[1])); // R5

    AST_LEG_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |=> (gate == '0)); // R7

endmodule

// File: rtl/psfb_rect_latch.sv
module psfb_rect_latch (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst || !en)  q_o <= 1'b0;
        else if (clr_i)  q_o <= 1'b0;
        else if (set_i)  q_o <= 1'b1;
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !q_o); // R6

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (en && set_i && !clr_i) |=> q_o); // R6

endmodule

// File: rtl/psfb_gate_gen.sv
module psfb_gate_gen
    import psfb_pkg::*;
#(
    parameter int DEAD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DEAD_W-1:0] dead_cycles,
    input  logic              ref_pulse_i,
    input  logic              pwm_pulse_i,
    output logic              gate_a,
    output logic              gate_b,
    output logic              gate_c,
    output logic              gate_d,
    output logic              rect_e,
    output logic              rect_f
);
    logic [LEG_COUNT-1:0]  pulse_in;
    logic [LEG_COUNT-1:0]  flip;
    gate_pair_t            leg_gate [LEG_COUNT];
    logic [SIDE_COUNT-1:0] lead_v;
    logic [SIDE_COUNT-1:0] lag_v;
    logic [SIDE_COUNT-1:0] rect;

    assign pulse_in[LEG_LEAD] = ref_pulse_i;
    assign pulse_in[LEG_LAG]  = pwm_pulse_i;

    for (genvar l = 0; l < LEG_COUNT; l++) begin : g_leg
        psfb_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk     (clk),
            .rst     (rst),
            .async_i (pulse_in[l]),
            .rise_o  (flip[l])
        );
        psfb_leg #(.CW(DEAD_W)) leg_i (
            .clk    (clk),
            .rst    (rst),
            .en     (en),
            .flip_i (flip[l]),
            .dead_i (dead_cycles),
            .gate_o (leg_gate[l])
        );
    end

    assign lead_v = {leg_gate[LEG_LEAD].comp_o, leg_gate[LEG_LEAD].true_o};
    assign lag_v  = {leg_gate[LEG_LAG].comp_o,  leg_gate[LEG_LAG].true_o};

    for (genvar s = 0; s < SIDE_COUNT; s++) begin : g_rect
        psfb_rect_latch latch_i (
            .clk   (clk),
            .rst   (rst),
            .en    (en),
            .set_i (lead_v[s]),
            .clr_i (lag_v[s]),
            .q_o   (rect[s])
        );
    end

    assign gate_a = lead_v[0];
    assign gate_b = lead_v[1];
    assign gate_c = lag_v[0];
    assign gate_d = lag_v[1];
    assign rect_e = rect[0];
    assign rect_f = rect[1];

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> ({gate_a, gate_b, gate_c, gate_d, rect_e, rect_f} == 6'b0)); // R1

    AST_ENABLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |=> ({gate_a, gate_b, gate_c, gate_d, rect_e, rect_f} == 6'b0)); // R7

endmodule

// File: tb/psfb_gate_gen_tb_top.sv
module psfb_gate_gen_tb_top;

    localparam int DW       = 8;
    localparam int PER      = 50;
    localparam int WD_LIMIT = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [DW-1:0] dead_cycles = 8'd4;
    logic          ref_pulse_i = 1'b0;
    logic          pwm_pulse_i = 1'b0;
    logic gate_a, gate_b, gate_c, gate_d, rect_e, rect_f;

    int  checks = 0;
    int  errors = 0;
    int  overlaps = 0;
    int  cyc = 0;
    bit  done = 0;

    // stimulus shape
    bit  run = 0;
    int  off = 20;
    int  pw  = 5;
    int  tc  = 0;

    always #4 clk = ~clk;

    psfb_gate_gen #(.DEAD_W(DW), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .en(en), .dead_cycles(dead_cycles),
        .ref_pulse_i(ref_pulse_i), .pwm_pulse_i(pwm_pulse_i),
        .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c), .gate_d(gate_d),
        .rect_e(rect_e), .rect_f(rect_f)
    );

    logic [5:0] gv;
    assign gv = {gate_a, gate_b, gate_c, gate_d, rect_e, rect_f};

    // pulse trains, changed at falling edges
    always @(negedge clk) begin
        tc <= tc + 1;
        ref_pulse_i <= run && ((tc % PER) < 45);
        pwm_pulse_i <= run && (((tc + off) % PER) < pw);
    end

    // reference model built from the requirements; pushes one expected item per cycle
    bit arm [2];
    bit st  [2];
    int cnt [2][2];
    bit rs  [2][3];
    bit me, mf;
    logic [5:0] sb [$];

    function automatic bit mlvl(int l, int s);
        return arm[l] & (s != 0 ? ~st[l] : st[l]);
    endfunction

    function automatic bit mgate(int l, int s);
        return mlvl(l, s) && (cnt[l][s] >= int'(dead_cycles));
    endfunction

    always @(posedge clk) begin
        bit og [2][2];
        bit ed [2];
        bit inp [2];
        if (rst) begin
            for (int l = 0; l < 2; l++) begin
                arm[l] = 0; st[l] = 0;
                for (int s = 0; s < 2; s++) cnt[l][s] = 0;
                for (int k = 0; k < 3; k++) rs[l][k] = 0;
            end
            me = 0; mf = 0;
        end else begin
            for (int l = 0; l < 2; l++)
                for (int s = 0; s < 2; s++) og[l][s] = mgate(l, s);
            // R6 latches: clear (lagging) beats set (leading)
            if (!en) me = 0; else if (og[1][0]) me = 0; else if (og[0][0]) me = 1;
            if (!en) mf = 0; else if (og[1][1]) mf = 0; else if (og[0][1]) mf = 1;
            for (int l = 0; l < 2; l++)
                for (int s = 0; s < 2; s++)
                    if (!mlvl(l, s)) cnt[l][s] = 0;
                    else if (cnt[l][s] < 255) cnt[l][s] = cnt[l][s] + 1;
            inp[0] = ref_pulse_i;
            inp[1] = pwm_pulse_i;
            for (int l = 0; l < 2; l++) begin
                ed[l] = rs[l][1] & ~rs[l][2];
                rs[l][2] = rs[l][1];
                rs[l][1] = rs[l][0];
                rs[l][0] = inp[l];
            end
            for (int l = 0; l < 2; l++)
                if (!en) begin arm[l] = 0; st[l] = 0; end
                else if (ed[l]) begin arm[l] = 1; st[l] = ~st[l]; end
        end
        sb.push_back({mgate(0,0), mgate(0,1), mgate(1,0), mgate(1,1), me, mf});
    end

    // monitor: pops expected items away from the active edge
    always @(posedge clk) begin
        logic [5:0] exp_v;
        #2;
        if (sb.size() > 0) begin
            exp_v = sb.pop_front();
            checks++;
            if (exp_v !== gv) begin
                errors++;
                if (errors < 20)
                    $display("FAIL %s scoreboard t=%0t actual=%b expected=%b",
                             (exp_v[5:2] !== gv[5:2]) ? "R4" : "R6", $time, gv, exp_v);
            end
        end
        if ((gate_a && gate_b) || (gate_c && gate_d)) overlaps++;
    end

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic step();
        @(posedge clk); #2;
    endtask

    // length of the next complete high pulse of output idx (bit of gv)
    task automatic meas_high(input int idx, output int len);
        int guard;
        len = 0;
        guard = 0;
        while (gv[idx] && guard < 400) begin step(); guard++; end
        while (!gv[idx] && guard < 400) begin step(); guard++; end
        while (gv[idx] && guard < 400) begin step(); guard++; len++; end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WD_LIMIT && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int len;
        int ecount;
        int acount;
        repeat (4) step();
        chk("R1 reset outputs", int'(gv), 0);

        // main run: dead time 4, lagging pulses shifted by 20 cycles
        @(negedge clk);
        rst <= 1'b0; en <= 1'b1; run <= 1'b1;
        repeat (200) step();
        meas_high(5, len); chk("R4 gate_a high time dead=4", len, PER - 4);
        meas_high(4, len); chk("R2 gate_b high time dead=4", len, PER - 4);
        meas_high(3, len); chk("R3 gate_c high time dead=4", len, PER - 4);
        meas_high(2, len); chk("R3 gate_d high time dead=4", len, PER - 4);
        ecount = 0;
        for (int i = 0; i < 200; i++) begin step(); if (rect_e) ecount++; end
        chk("R6 rect_e active with shifted legs", int'(ecount > 0), 1);

        // zero dead time
        @(negedge clk); dead_cycles <= 8'd0;
        repeat (120) step();
        meas_high(5, len); chk("R4 gate_a high time dead=0", len, PER);

        // enable drop
        @(negedge clk); en <= 1'b0;
        step();
        chk("R7 outputs low one cycle after enable drop", int'(gv), 0);
        repeat (20) step();
        chk("R7 outputs stay low while disabled", int'(gv), 0);
        @(negedge clk); en <= 1'b1; dead_cycles <= 8'd7;
        repeat (300) step();
        meas_high(3, len); chk("R3 gate_c high time dead=7", len, PER - 7);

        // identical input trains: set and clear coincide in both latches
        @(negedge clk); rst <= 1'b1; pw <= 45; off <= 0;
        repeat (3) step();
        chk("R1 outputs low during reset", int'(gv), 0);
        @(negedge clk); rst <= 1'b0;
        repeat (100) step();
        ecount = 0;
        acount = 0;
        for (int i = 0; i < 300; i++) begin
            step();
            if (rect_e || rect_f) ecount++;
            if (gate_a) acount++;
        end
        chk("R6 clear wins keeps rectifiers low", ecount, 0);
        chk("R2 leading leg still switching", int'(acount > 0), 1);

        repeat (5) step();
        chk("R5 no same-cycle leg overlap", overlaps, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule